// File: doc/BRIEF.md
# Color-Steered Register Port

This block sits between an 8-bit parallel microprocessor bus and a three-channel imaging datapath. The host selects the block with an active-low chip select and moves bytes with active-low read and write strobes. A 3-bit address chooses one of eight slots. Four of these slots are per-color: programmable gain, odd-pixel offset, even-pixel offset and input offset. Each one has a separate red, green and blue copy.

A 2-bit color pointer sits in the top two bits of the main configuration byte. It decides which copy a per-color access reaches. Software therefore writes the pointer first, then writes the shared address once for each color.

All stored values are exported continuously to the datapath. The scaling and width select fields are also exported with their decoded bypass flags. The strobes are sampled synchronously by the block clock, so bus timing is expressed in clock edges.

Top module: `cpreg_port`

## Requirements
- R1: Address decode: 000 main configuration, 001 second configuration, 010 gain, 011 odd offset, 100 even offset, 101 input offset, 110 reserved, 111 Bayer-mode byte; a write to any valid address reads back the written byte.
- R2: A write takes effect when wr_ni rises while cs_ni is low, and becomes visible on the exported outputs two rising clock edges after that rise; holding wr_ni low changes nothing.
- R3: A write strobe with cs_ni high changes no register.
- R4: Configuration bits [7:6] form the color pointer, with 00 red, 01 green and 10 blue. A per-color write updates only the copy the pointer selects, and a per-color read returns that copy.
- R5: With pointer code 11, per-color writes are discarded and per-color reads return 0x00.
- R6: Writes to the reserved address 110 are discarded, and reads of it return 0x00.
- R7: data_oe_o is high exactly while cs_ni and rd_ni are both low, in the same cycle. At that time data_o carries the addressed register; otherwise data_o is 0x00 and the pad is to float.
- R8: Per-color exports pack red in bits [7:0], green in [15:8] and blue in [23:16].
- R9: scale_sel_o is configuration bits [2:0] and width_sel_o is bits [5:3]. mult_bypass_o is high when scale_sel_o is zero, and sub_bypass_o is high when width_sel_o is zero.
- R10: Reset (rst_ni low) clears every register to zero, so both bypass flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low, captured on its rising edge |
| addr_i | input | 3 | Register address |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data toward the bus |
| data_oe_o | output | 1 | Bus drive enable for the pad |
| cfg_o | output | 8 | Main configuration byte |
| cfg2_o | output | 8 | Second configuration byte |
| bayer_o | output | 8 | Bayer-mode byte |
| gain_o | output | 24 | Gain, three colors packed |
| odd_ofs_o | output | 24 | Odd offset, three colors packed |
| even_ofs_o | output | 24 | Even offset, three colors packed |
| in_ofs_o | output | 24 | Input offset, three colors packed |
| color_ptr_o | output | 2 | Current color pointer |
| scale_sel_o | output | 3 | Digital scaling selects |
| width_sel_o | output | 3 | Gain/offset width selects |
| mult_bypass_o | output | 1 | Digital multiplier bypassed |
| sub_bypass_o | output | 1 | Digital subtractor bypassed |

## Verification
A write lands two rising edges after wr_ni rises. The bench therefore lets three falling edges pass after raising the strobe before it looks at the exports or reads back. Readback and drive enable are combinational from the current registers and bus pins. The bench reads 2 ns after driving the strobes, within the same low clock phase. The hold-low test samples the exports four cycles into a held strobe to confirm that nothing moves before the rise.

// File: rtl/cpreg_pkg.sv
package cpreg_pkg;
  localparam int AW  = 3;
  localparam int CPW = 2;

  typedef enum logic [AW-1:0] {
    ADR_CFG   = 3'd0,
    ADR_CFG2  = 3'd1,
    ADR_GAIN  = 3'd2,
    ADR_ODD   = 3'd3,
    ADR_EVEN  = 3'd4,
    ADR_INOFS = 3'd5,
    ADR_RSVD  = 3'd6,
    ADR_BAYER = 3'd7
  } addr_e;

  typedef enum logic [CPW-1:0] {
    COL_RED   = 2'd0,
    COL_GREEN = 2'd1,
    COL_BLUE  = 2'd2,
    COL_NONE  = 2'd3
  } color_e;
endpackage

// File: rtl/cpreg_strobe_sync.sv
module cpreg_strobe_sync
  import cpreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_pulse_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          cs_s, wr_s, wr_d;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_s   <= 1'b1;
      wr_s   <= 1'b1;
      wr_d   <= 1'b1;
      addr_s <= '0;
      data_s <= '0;
    end else begin
      cs_s   <= cs_ni;
      wr_s   <= wr_ni;
      wr_d   <= wr_s;
      addr_s <= addr_i;
      data_s <= data_i;
    end
  end

  assign wr_pulse_o = wr_s & ~wr_d & ~cs_s;
  assign wr_addr_o  = addr_s;
  assign wr_data_o  = data_s;
endmodule

// File: rtl/cpreg_color_bank.sv
module cpreg_color_bank
  import cpreg_pkg::*;
#(
  parameter int DW = 8,
  parameter int NC = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [CPW-1:0] sel_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [NC*DW-1:0] q_o
);
  for (genvar c = 0; c < NC; c++) begin : g_col
    logic [DW-1:0] r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r <= '0;
      else if (we_i && (sel_i == CPW'(c))) r <= wdata_i;
    end
    assign q_o[c*DW +: DW] = r;
  end
endmodule

// File: rtl/cpreg_read_mux.sv
module cpreg_read_mux
  import cpreg_pkg::*;
#(
  parameter int DW = 8,
  parameter int NC = 3
) (
  input  logic             rd_act_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CPW-1:0]   cptr_i,
  input  logic [DW-1:0]    cfg_i,
  input  logic [DW-1:0]    cfg2_i,
  input  logic [DW-1:0]    bayer_i,
  input  logic [NC*DW-1:0] gain_i,
  input  logic [NC*DW-1:0] odd_i,
  input  logic [NC*DW-1:0] even_i,
  input  logic [NC*DW-1:0] inofs_i,
  output logic [DW-1:0]    data_o
);
  logic          ptr_ok;
  logic [DW-1:0] sel_gain, sel_odd, sel_even, sel_inofs, word;

  assign ptr_ok = (int'(cptr_i) < NC);

  always_comb begin
    sel_gain  = '0;
    sel_odd   = '0;
    sel_even  = '0;
    sel_inofs = '0;
    for (int c = 0; c < NC; c++) begin
      if (ptr_ok && (int'(cptr_i) == c)) begin
        sel_gain  = gain_i[c*DW +: DW];
        sel_odd   = odd_i[c*DW +: DW];
        sel_even  = even_i[c*DW +: DW];
        sel_inofs = inofs_i[c*DW +: DW];
      end
    end
  end

  always_comb begin
    case (addr_e'(addr_i))
      ADR_CFG:   word = cfg_i;
      ADR_CFG2:  word = cfg2_i;
      ADR_GAIN:  word = sel_gain;
      ADR_ODD:   word = sel_odd;
      ADR_EVEN:  word = sel_even;
      ADR_INOFS: word = sel_inofs;
      ADR_BAYER: word = bayer_i;
      default:   word = '0;
    endcase
  end

  assign data_o = rd_act_i ? word : '0;
endmodule

// File: rtl/cpreg_port.sv
module cpreg_port
  import cpreg_pkg::*;
#(
  parameter int DW = 8,
  parameter int NC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o,
  output logic             data_oe_o,
  output logic [DW-1:0]    cfg_o,
  output logic [DW-1:0]    cfg2_o,
  output logic [DW-1:0]    bayer_o,
  output logic [NC*DW-1:0] gain_o,
  output logic [NC*DW-1:0] odd_ofs_o,
  output logic [NC*DW-1:0] even_ofs_o,
  output logic [NC*DW-1:0] in_ofs_o,
  output logic [CPW-1:0]   color_ptr_o,
  output logic [2:0]       scale_sel_o,
  output logic [2:0]       width_sel_o,
  output logic             mult_bypass_o,
  output logic             sub_bypass_o
);
  localparam int BW = NC * DW;

  logic          wr_pulse;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] cfg_q, cfg2_q, bayer_q;
  logic [BW-1:0] gain_q, odd_q, even_q, inofs_q;
  logic [CPW-1:0] cptr;
  logic          we_gain, we_odd, we_even, we_inofs;
  logic          rd_act;

  cpreg_strobe_sync #(.DW(DW)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .wr_ni      (wr_ni),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .wr_pulse_o (wr_pulse),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cfg2_q  <= '0;
      bayer_q <= '0;
    end else if (wr_pulse) begin
      case (addr_e'(wr_addr))
        ADR_CFG:   cfg_q   <= wr_data;
        ADR_CFG2:  cfg2_q  <= wr_data;
        ADR_BAYER: bayer_q <= wr_data;
        default:   ;
      endcase
    end
  end

  assign cptr = cfg_q[DW-1 -: CPW];

  always_comb begin
    we_gain  = wr_pulse && (wr_addr == ADR_GAIN);
    we_odd   = wr_pulse && (wr_addr == ADR_ODD);
    we_even  = wr_pulse && (wr_addr == ADR_EVEN);
    we_inofs = wr_pulse && (wr_addr == ADR_INOFS);
  end

  cpreg_color_bank #(.DW(DW), .NC(NC)) u_gain (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_gain),
    .sel_i(cptr), .wdata_i(wr_data), .q_o(gain_q));
  cpreg_color_bank #(.DW(DW), .NC(NC)) u_odd (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_odd),
    .sel_i(cptr), .wdata_i(wr_data), .q_o(odd_q));
  cpreg_color_bank #(.DW(DW), .NC(NC)) u_even (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_even),
    .sel_i(cptr), .wdata_i(wr_data), .q_o(even_q));
  cpreg_color_bank #(.DW(DW), .NC(NC)) u_inofs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_inofs),
    .sel_i(cptr), .wdata_i(wr_data), .q_o(inofs_q));

  assign rd_act = ~cs_ni & ~rd_ni;

  cpreg_read_mux #(.DW(DW), .NC(NC)) u_rmux (
    .rd_act_i (rd_act),
    .addr_i   (addr_i),
    .cptr_i   (cptr),
    .cfg_i    (cfg_q),
    .cfg2_i   (cfg2_q),
    .bayer_i  (bayer_q),
    .gain_i   (gain_q),
    .odd_i    (odd_q),
    .even_i   (even_q),
    .inofs_i  (inofs_q),
    .data_o   (data_o)
  );

  assign data_oe_o     = rd_act;
  assign cfg_o         = cfg_q;
  assign cfg2_o        = cfg2_q;
  assign bayer_o       = bayer_q;
  assign gain_o        = gain_q;
  assign odd_ofs_o     = odd_q;
  assign even_ofs_o    = even_q;
  assign in_ofs_o      = inofs_q;
  assign color_ptr_o   = cptr;
  assign scale_sel_o   = cfg_q[2:0];
  assign width_sel_o   = cfg_q[5:3];
  assign mult_bypass_o = (cfg_q[2:0] == 3'd0);
  assign sub_bypass_o  = (cfg_q[5:3] == 3'd0);
endmodule

// File: rtl/cpreg_port_chk.sv
module cpreg_port_chk #(
  parameter int DW = 8,
  parameter int NC = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             rd_ni,
  input logic             wr_pulse,
  input logic [2:0]       wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [1:0]       cptr,
  input logic [DW-1:0]    cfg_q,
  input logic [DW-1:0]    cfg2_q,
  input logic [DW-1:0]    bayer_q,
  input logic [NC*DW-1:0] gain_q,
  input logic [NC*DW-1:0] odd_q,
  input logic [NC*DW-1:0] even_q,
  input logic [NC*DW-1:0] inofs_q,
  input logic [DW-1:0]    data_o,
  input logic             data_oe_o
);
  p_quiet_without_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pulse |=> ($stable(cfg_q) && $stable(cfg2_q) && $stable(bayer_q) &&
                   $stable(gain_q) && $stable(odd_q) && $stable(even_q) && $stable(inofs_q)));

  p_red_gain_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pulse && wr_addr == 3'd2 && cptr == 2'd0) |=> (gain_q[DW-1:0] == $past(wr_data)));

  p_null_pointer_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pulse && cptr == 2'd3) |=> ($stable(gain_q) && $stable(odd_q) &&
                                    $stable(even_q) && $stable(inofs_q)));

  p_reserved_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pulse && wr_addr == 3'd6) |=> ($stable(cfg_q) && $stable(cfg2_q) && $stable(bayer_q) &&
                                       $stable(gain_q) && $stable(odd_q) && $stable(even_q) &&
                                       $stable(inofs_q)));

  p_bus_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> (!data_oe_o && data_o == '0));

  p_reset_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cfg_q == '0 && gain_q == '0 && odd_q == '0 && even_q == '0));
endmodule

bind cpreg_port cpreg_port_chk #(.DW(DW), .NC(NC)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .wr_pulse  (wr_pulse),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .cptr      (cptr),
  .cfg_q     (cfg_q),
  .cfg2_q    (cfg2_q),
  .bayer_q   (bayer_q),
  .gain_q    (gain_q),
  .odd_q     (odd_q),
  .even_q    (even_q),
  .inofs_q   (inofs_q),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/cpreg_port_tb.sv
module cpreg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout, cfg, cfg2, bayer;
  logic        oe, mbyp, sbyp;
  logic [23:0] gain, oddo, eveno, inofs;
  logic [1:0]  cptr;
  logic [2:0]  ssel, wsel;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  cpreg_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .cfg_o(cfg), .cfg2_o(cfg2), .bayer_o(bayer), .gain_o(gain),
    .odd_ofs_o(oddo), .even_ofs_o(eveno), .in_ofs_o(inofs),
    .color_ptr_o(cptr), .scale_sel_o(ssel), .width_sel_o(wsel),
    .mult_bypass_o(mbyp), .sub_bypass_o(sbyp));

  // {pointer, address, write byte, expected readback}
  localparam logic [20:0] VEC [0:9] = '{
    {2'd0, 3'd2, 8'h11, 8'h11},
    {2'd1, 3'd2, 8'h22, 8'h22},
    {2'd2, 3'd2, 8'h33, 8'h33},
    {2'd0, 3'd3, 8'h44, 8'h44},
    {2'd1, 3'd4, 8'h55, 8'h55},
    {2'd2, 3'd5, 8'h66, 8'h66},
    {2'd3, 3'd2, 8'h77, 8'h00},
    {2'd0, 3'd6, 8'h88, 8'h00},
    {2'd1, 3'd1, 8'h99, 8'h99},
    {2'd2, 3'd7, 8'hAA, 8'hAA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk); addr = a; din = d; cs_n = sel_n; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d, output logic e);
    @(negedge clk); addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #2; d = dout; e = oe;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    logic       e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 cfg", cfg, 0);
    chk("R10 gain", gain, 0);
    chk("R10 bypass", {mbyp, sbyp}, 2'b11);

    for (int i = 0; i < 10; i++) begin
      logic [1:0] p;
      logic [2:0] a;
      logic [7:0] w, x;
      {p, a, w, x} = VEC[i];
      bus_write(3'd0, {p, 6'd0}, 1'b0);
      bus_write(a, w, 1'b0);
      bus_read(a, rd, e);
      chk("R1 R4 R5 R6 table readback", rd, x);
      chk("R7 oe during read", e, 1'b1);
    end

    // R4 each color kept separately, pointer 11 write left them alone (R5)
    for (int c = 0; c < 3; c++) begin
      bus_write(3'd0, 8'(c << 6), 1'b0);
      bus_read(3'd2, rd, e);
      chk("R4 gain per color", rd, 8'h11 * (c + 1));
    end
    bus_write(3'd0, 8'hC0, 1'b0);
    bus_read(3'd3, rd, e);
    chk("R5 null pointer read", rd, 8'h00);
    // R8 packing
    chk("R8 gain pack", gain, 24'h332211);
    chk("R8 odd pack", oddo, 24'h000044);
    chk("R8 even pack", eveno, 24'h005500);
    chk("R8 inofs pack", inofs, 24'h660000);

    // R3 deselected write
    bus_write(3'd1, 8'h3C, 1'b1);
    chk("R3 cfg2 kept", cfg2, 8'h99);

    // R2 held strobe does nothing until it rises
    @(negedge clk); addr = 3'd7; din = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 held low", bayer, 8'hAA);
    wr_n = 1'b1;
    @(negedge clk);
    chk("R2 one edge after rise", bayer, 8'hAA);
    @(negedge clk); cs_n = 1'b1;
    chk("R2 two edges after rise", bayer, 8'h5A);

    // R7 bus idle combinations
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; addr = 3'd7;
    #2; chk("R7 cs only oe", oe, 1'b0); chk("R7 cs only data", dout, 8'h00);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    #2; chk("R7 rd only oe", oe, 1'b0); chk("R7 rd only data", dout, 8'h00);
    @(negedge clk); rd_n = 1'b1;

    // R9 field decode
    bus_write(3'd0, 8'h05, 1'b0);
    chk("R9 scale", ssel, 3'd5);
    chk("R9 bypass a", {mbyp, sbyp}, 2'b01);
    bus_write(3'd0, 8'h98, 1'b0);
    chk("R9 width", wsel, 3'd3);
    chk("R9 bypass b", {mbyp, sbyp}, 2'b10);
    chk("R4 pointer export", cptr, 2'd2);
    bus_read(3'd0, rd, e);
    chk("R1 cfg readback", rd, 8'h98);

    // R10 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 clear cfg", cfg, 0);
    chk("R10 clear banks", {gain, oddo, eveno, inofs}, 96'd0);
    chk("R10 clear bytes", {cfg2, bayer}, 16'd0);
    chk("R10 bypass again", {mbyp, sbyp}, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule